// File: doc/BRIEF.md
# Deferred Parity Error Signalling Unit

This unit decides when a parity failure in an instruction queue turns into a fatal error. A parity check that fails when an instruction issues does not stop the machine. The failure only sets a "suspect" mark on that queue entry. The mark then follows the instruction. Instructions that cannot affect results are filtered out along the way:

- Error-neutral instructions (no-ops, prefetches, branch hints) arrive with an immunity flag, so their entries are never marked.
- Squashed wrong-path instructions simply drop their marks.
- Values that are written but never read later produce no error at all.

A mode pin picks where the check is made. In commit mode, a suspect instruction raises the error as it commits. In deferred mode, a suspect instruction that writes a register passes its mark to that register. The error then fires only when a later instruction reads that register.

Every input is a plain one-cycle strobe with its own valid bit. The unit has no ready signal and never applies back-pressure: each strobe is acted on in the cycle it is presented. The error output is a single-cycle registered pulse. It carries a source flag and the index of either the offending queue entry or the register.

Top module: `dpe_unit`

## Requirements
- R1: An issue strobe with the parity-fail bit set marks the addressed queue entry and produces no error pulse.
- R2: An issue strobe with the immunity flag set leaves the entry unmarked, even when parity fails, so that its later commit raises nothing.
- R3: In commit mode (defer_mode=0), committing a marked entry gives err_valid=1 in the next cycle with err_at_read=0 and err_idx equal to the entry index. Committing an unmarked entry gives no pulse. Commit releases the entry's mark.
- R4: A squash strobe clears the addressed entry's mark with no error pulse, so a later commit of that index raises nothing.
- R5: In deferred mode (defer_mode=1), a commit that writes a destination copies the entry's mark into bit commit_dst of reg_marks, which is visible in the next cycle, and produces no pulse.
- R6: A read strobe of a register whose mark is set gives err_valid=1 in the next cycle with err_at_read=1 and err_idx equal to the register number.
- R7: An unmarked register write clears that register's mark. A register overwritten before any read therefore never raises an error.
- R8: In deferred mode, committing a marked entry that has no destination raises the error at commit (err_at_read=0, err_idx = entry).
- R9: A read and a write of the same register in the same cycle use the register's mark from before the write.
- R10: When a commit error and a read error occur in the same cycle, the commit error is reported.
- R11: Reset clears all entry marks, all register marks and err_valid.
- R12: In commit mode every register write leaves the register's mark clear, including the write of a marked instruction (which errors at commit).
- R13: An issue and a squash to the same entry in the same cycle leave the entry holding the new issue's mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| defer_mode | input | 1 | 0: error at commit, 1: error deferred to register read |
| issue_valid | input | 1 | Issue strobe |
| issue_idx | input | QW | Queue entry being issued |
| issue_parity_err | input | 1 | Parity check failed at issue |
| issue_anti | input | 1 | Instruction is neutral to errors (immunity flag) |
| squash_valid | input | 1 | Wrong-path squash strobe |
| squash_idx | input | QW | Entry being squashed |
| commit_valid | input | 1 | Commit strobe |
| commit_idx | input | QW | Entry being committed |
| commit_dst_valid | input | 1 | Committing instruction writes a register |
| commit_dst | input | RW | Destination register |
| rd_valid | input | 1 | Register read strobe |
| rd_reg | input | RW | Register being read |
| err_valid | output | 1 | Fatal error pulse |
| err_at_read | output | 1 | 1: raised by a register read, 0: raised by a commit |
| err_idx | output | IW | Entry or register index of the error |
| reg_marks | output | NREGS | Current per-register mark state |

## Verification
The bench builds the unit with QDEPTH=8 and NREGS=8, so that 3-bit indices reach both ends of the entry and register ranges, and the whole register mark vector can be compared in every step. With these small sizes, each ordering case fits in a short table: same-cycle read and write, commit error against read error, and issue against squash. The mode pin is switched during the run, and marks left over from deferred mode are checked under commit mode.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
  typedef enum logic {
    SRC_COMMIT = 1'b0,
    SRC_READ   = 1'b1
  } err_src_e;
endpackage

// File: rtl/dpe_entry_marks.sv
module dpe_entry_marks #(
  parameter int QDEPTH = 16,
  parameter int QW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [QW-1:0]     issue_idx,
  input  logic              issue_set,
  input  logic              squash_valid,
  input  logic [QW-1:0]     squash_idx,
  input  logic              commit_valid,
  input  logic [QW-1:0]     commit_idx,
  output logic [QDEPTH-1:0] marks
);
  for (genvar e = 0; e < QDEPTH; e++) begin : g_entry
    logic hit_issue, hit_clear;
    assign hit_issue = issue_valid && (issue_idx == QW'(e));
    assign hit_clear = (squash_valid && (squash_idx == QW'(e))) ||
                       (commit_valid && (commit_idx == QW'(e)));
    always_ff @(posedge clk) begin
      if (!rst_n)         marks[e] <= 1'b0;
      else if (hit_issue) marks[e] <= issue_set;
      else if (hit_clear) marks[e] <= 1'b0;
    end
  end

  // squash without a competing issue leaves the entry clean
  p_squash_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && !(issue_valid && issue_idx == squash_idx))
      |=> !marks[$past(squash_idx)]);

  // issue and squash together: the new occupant's mark wins
  p_issue_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && squash_valid && issue_idx == squash_idx)
      |=> marks[$past(issue_idx)] == $past(issue_set));
endmodule

// File: rtl/dpe_reg_marks.sv
module dpe_reg_marks #(
  parameter int NREGS = 32,
  parameter int RW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [RW-1:0]    wr_reg,
  input  logic             wr_mark,
  output logic [NREGS-1:0] marks
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                              marks[r] <= 1'b0;
      else if (wr_valid && wr_reg == RW'(r))   marks[r] <= wr_mark;
    end
  end

  p_mark_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> marks[$past(wr_reg)] == $past(wr_mark));
endmodule

// File: rtl/dpe_err_report.sv
module dpe_err_report
  import dpe_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_hit,
  input  logic [IW-1:0] commit_idx,
  input  logic          read_hit,
  input  logic [IW-1:0] read_idx,
  output logic          err_valid,
  output logic          err_at_read,
  output logic [IW-1:0] err_idx
);
  err_src_e src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      src_q     <= SRC_COMMIT;
      err_idx   <= '0;
    end else begin
      err_valid <= commit_hit || read_hit;
      if (commit_hit) begin
        src_q   <= SRC_COMMIT;
        err_idx <= commit_idx;
      end else if (read_hit) begin
        src_q   <= SRC_READ;
        err_idx <= read_idx;
      end
    end
  end

  assign err_at_read = (src_q == SRC_READ);

  p_commit_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_hit && read_hit) |=> (err_valid && !err_at_read));
endmodule

// File: rtl/dpe_unit.sv
module dpe_unit #(
  parameter int QDEPTH = 16,
  parameter int NREGS  = 32,
  localparam int QW = $clog2(QDEPTH),
  localparam int RW = $clog2(NREGS),
  localparam int IW = (QW > RW) ? QW : RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             defer_mode,
  input  logic             issue_valid,
  input  logic [QW-1:0]    issue_idx,
  input  logic             issue_parity_err,
  input  logic             issue_anti,
  input  logic             squash_valid,
  input  logic [QW-1:0]    squash_idx,
  input  logic             commit_valid,
  input  logic [QW-1:0]    commit_idx,
  input  logic             commit_dst_valid,
  input  logic [RW-1:0]    commit_dst,
  input  logic             rd_valid,
  input  logic [RW-1:0]    rd_reg,
  output logic             err_valid,
  output logic             err_at_read,
  output logic [IW-1:0]    err_idx,
  output logic [NREGS-1:0] reg_marks
);
  logic [QDEPTH-1:0] entry_marks;
  logic commit_mark, commit_hit, read_hit, wr_valid, wr_mark;

  dpe_entry_marks #(.QDEPTH(QDEPTH), .QW(QW)) u_entries (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_idx(issue_idx),
    .issue_set(issue_parity_err && !issue_anti),
    .squash_valid(squash_valid), .squash_idx(squash_idx),
    .commit_valid(commit_valid), .commit_idx(commit_idx),
    .marks(entry_marks)
  );

  assign commit_mark = entry_marks[commit_idx];
  // with a destination in deferred mode the mark travels instead of firing
  assign commit_hit  = commit_valid && commit_mark &&
                       !(defer_mode && commit_dst_valid);
  assign wr_valid    = commit_valid && commit_dst_valid;
  assign wr_mark     = defer_mode && commit_mark;

  dpe_reg_marks #(.NREGS(NREGS), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_reg(commit_dst), .wr_mark(wr_mark),
    .marks(reg_marks)
  );

  assign read_hit = rd_valid && reg_marks[rd_reg];

  dpe_err_report #(.IW(IW)) u_report (
    .clk(clk), .rst_n(rst_n),
    .commit_hit(commit_hit), .commit_idx(IW'(commit_idx)),
    .read_hit(read_hit), .read_idx(IW'(rd_reg)),
    .err_valid(err_valid), .err_at_read(err_at_read), .err_idx(err_idx)
  );

  p_anti_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_anti) |=> !entry_marks[$past(issue_idx)]);

  p_commit_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_at_read)
      |-> ($past(commit_valid) && $past(commit_mark) &&
           err_idx == IW'($past(commit_idx))));

  p_read_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_at_read)
      |-> ($past(rd_valid) && $past(reg_marks[rd_reg]) &&
           err_idx == IW'($past(rd_reg))));

  p_commit_mode_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!defer_mode && wr_valid) |=> !reg_marks[$past(commit_dst)]);
endmodule

// File: tb/dpe_unit_test.sv
module dpe_unit_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, defer_mode;
  logic issue_valid, issue_parity_err, issue_anti, squash_valid;
  logic commit_valid, commit_dst_valid, rd_valid;
  logic [2:0] issue_idx, squash_idx, commit_idx, commit_dst, rd_reg;
  logic err_valid, err_at_read;
  logic [2:0] err_idx;
  logic [7:0] reg_marks;

  dpe_unit #(.QDEPTH(8), .NREGS(8)) uut (
    .clk(clk), .rst_n(rst_n), .defer_mode(defer_mode),
    .issue_valid(issue_valid), .issue_idx(issue_idx),
    .issue_parity_err(issue_parity_err), .issue_anti(issue_anti),
    .squash_valid(squash_valid), .squash_idx(squash_idx),
    .commit_valid(commit_valid), .commit_idx(commit_idx),
    .commit_dst_valid(commit_dst_valid), .commit_dst(commit_dst),
    .rd_valid(rd_valid), .rd_reg(rd_reg),
    .err_valid(err_valid), .err_at_read(err_at_read), .err_idx(err_idx),
    .reg_marks(reg_marks)
  );

  typedef struct packed {
    logic mode; logic iv; logic [2:0] ii; logic par; logic anti;
    logic sv; logic [2:0] si;
    logic cv; logic [2:0] ci; logic dv; logic [2:0] dr;
    logic rv; logic [2:0] rr;
    logic ev; logic es; logic [2:0] ei; logic [7:0] em; logic [7:0] rq;
  } vec_t;

  localparam int NV = 29;
  // mode iv ii par anti sv si cv ci dv dr rv rr | ev es ei em rq
  localparam vec_t VEC [NV] = '{
    '{0,1,2,1,0, 0,0, 0,0,0,0, 0,0, 0,0,0,8'h00,1},   // R1 mark entry 2, no pulse
    '{0,1,3,1,1, 0,0, 0,0,0,0, 0,0, 0,0,0,8'h00,2},   // R2 immune issue
    '{0,0,0,0,0, 0,0, 1,3,1,1, 0,0, 0,0,0,8'h00,2},   // R2 commit immune: silent
    '{0,0,0,0,0, 0,0, 1,2,0,0, 0,0, 1,0,2,8'h00,3},   // R3 commit error entry 2
    '{0,0,0,0,0, 0,0, 1,2,0,0, 0,0, 0,0,0,8'h00,3},   // R3 mark released
    '{0,1,5,1,0, 0,0, 0,0,0,0, 0,0, 0,0,0,8'h00,4},
    '{0,0,0,0,0, 1,5, 0,0,0,0, 0,0, 0,0,0,8'h00,4},   // R4 squash
    '{0,0,0,0,0, 0,0, 1,5,0,0, 0,0, 0,0,0,8'h00,4},   // R4 no error later
    '{1,1,0,1,0, 0,0, 0,0,0,0, 0,0, 0,0,0,8'h00,5},
    '{1,0,0,0,0, 0,0, 1,0,1,4, 0,0, 0,0,0,8'h10,5},   // R5 mark moves to r4
    '{1,0,0,0,0, 0,0, 0,0,0,0, 1,4, 1,1,4,8'h10,6},   // R6 read r4
    '{1,1,1,0,0, 0,0, 0,0,0,0, 0,0, 0,0,0,8'h10,7},
    '{1,0,0,0,0, 0,0, 1,1,1,4, 0,0, 0,0,0,8'h00,7},   // R7 clean overwrite
    '{1,0,0,0,0, 0,0, 0,0,0,0, 1,4, 0,0,0,8'h00,7},   // R7 read silent
    '{1,1,6,1,0, 0,0, 0,0,0,0, 0,0, 0,0,0,8'h00,8},
    '{1,0,0,0,0, 0,0, 1,6,0,0, 0,0, 1,0,6,8'h00,8},   // R8 no-dest commit errs
    '{1,1,7,1,0, 0,0, 0,0,0,0, 0,0, 0,0,0,8'h00,9},
    '{1,0,0,0,0, 0,0, 1,7,1,7, 0,0, 0,0,0,8'h80,9},
    '{1,1,1,0,0, 0,0, 0,0,0,0, 0,0, 0,0,0,8'h80,9},
    '{1,0,0,0,0, 0,0, 1,1,1,7, 1,7, 1,1,7,8'h00,9},   // R9 read sees old mark
    '{1,1,0,1,0, 0,0, 0,0,0,0, 0,0, 0,0,0,8'h00,10},
    '{1,0,0,0,0, 0,0, 1,0,1,2, 0,0, 0,0,0,8'h04,10},
    '{1,1,3,1,0, 0,0, 0,0,0,0, 0,0, 0,0,0,8'h04,10},
    '{1,0,0,0,0, 0,0, 1,3,0,0, 1,2, 1,0,3,8'h04,10},  // R10 commit wins
    '{0,1,4,1,0, 0,0, 0,0,0,0, 0,0, 0,0,0,8'h04,12},
    '{0,0,0,0,0, 0,0, 1,4,1,2, 0,0, 1,0,4,8'h00,12},  // R12 err, r2 clean
    '{0,0,0,0,0, 0,0, 0,0,0,0, 1,2, 0,0,0,8'h00,12},
    '{0,1,5,1,0, 1,5, 0,0,0,0, 0,0, 0,0,0,8'h00,13},  // R13 issue+squash
    '{0,0,0,0,0, 0,0, 1,5,0,0, 0,0, 1,0,5,8'h00,13}   // R13 mark kept
  };

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    issue_valid = 0; issue_idx = 0; issue_parity_err = 0; issue_anti = 0;
    squash_valid = 0; squash_idx = 0; commit_valid = 0; commit_idx = 0;
    commit_dst_valid = 0; commit_dst = 0; rd_valid = 0; rd_reg = 0;
  endtask

  initial begin
    rst_n = 0; defer_mode = 0; idle();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 err_valid", {7'b0, err_valid}, 8'h0);
    chk("R11 reg_marks", reg_marks, 8'h00);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      defer_mode = VEC[i].mode;
      issue_valid = VEC[i].iv; issue_idx = VEC[i].ii;
      issue_parity_err = VEC[i].par; issue_anti = VEC[i].anti;
      squash_valid = VEC[i].sv; squash_idx = VEC[i].si;
      commit_valid = VEC[i].cv; commit_idx = VEC[i].ci;
      commit_dst_valid = VEC[i].dv; commit_dst = VEC[i].dr;
      rd_valid = VEC[i].rv; rd_reg = VEC[i].rr;
      @(negedge clk);
      chk($sformatf("R%0d step %0d err_valid", VEC[i].rq, i), {7'b0, err_valid}, {7'b0, VEC[i].ev});
      if (VEC[i].ev) begin
        chk($sformatf("R%0d step %0d err_at_read", VEC[i].rq, i), {7'b0, err_at_read}, {7'b0, VEC[i].es});
        chk($sformatf("R%0d step %0d err_idx", VEC[i].rq, i), {5'b0, err_idx}, {5'b0, VEC[i].ei});
      end
      chk($sformatf("R%0d step %0d reg_marks", VEC[i].rq, i), reg_marks, VEC[i].em);
    end
    idle();
    // R11 mid-run reset clears register and entry marks
    defer_mode = 1;
    issue_valid = 1; issue_idx = 7; issue_parity_err = 1;
    @(negedge clk); idle();
    commit_valid = 1; commit_idx = 7; commit_dst_valid = 1; commit_dst = 0;
    @(negedge clk); idle();
    chk("R5 r0 marked", reg_marks, 8'h01);
    issue_valid = 1; issue_idx = 6; issue_parity_err = 1;
    @(negedge clk); idle();
    rst_n = 0; @(negedge clk); rst_n = 1;
    chk("R11 reg_marks after reset", reg_marks, 8'h00);
    commit_valid = 1; commit_idx = 6;
    @(negedge clk); idle();
    chk("R11 entry cleared by reset", {7'b0, err_valid}, 8'h0);
    rd_valid = 1; rd_reg = 0;
    @(negedge clk); idle();
    chk("R11 read after reset silent", {7'b0, err_valid}, 8'h0);
    // R6 error is a one-cycle pulse
    issue_valid = 1; issue_idx = 0; issue_parity_err = 1;
    @(negedge clk); idle();
    commit_valid = 1; commit_idx = 0; commit_dst_valid = 1; commit_dst = 3;
    @(negedge clk); idle();
    rd_valid = 1; rd_reg = 3;
    @(negedge clk); idle();
    chk("R6 pulse", {err_valid, err_at_read, 3'b0, err_idx}, {2'b11, 3'b0, 3'd3});
    @(negedge clk);
    chk("R6 pulse ends", {7'b0, err_valid}, 8'h0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule